// File: doc/BRIEF.md
# Replicated Register Bank with Steering

This block holds several copies of one register, one copy per hardware unit, all reached through a single bus address. Units are arranged as groups of instances. A separate steering register names one group and one instance, and carries a broadcast flag. A write to the shared address with the flag set goes to every unit that is present. With the flag clear, the write goes only to the steered unit. A read of the shared address always returns the steered unit alone, whatever the flag says.

An availability mask input marks which units are present: a unit may be fused out or power-gated. An access steered to a missing unit is terminated. A read returns zero, and a single-target write is dropped. A group or instance number outside the configured range counts as a missing unit.

The bus is a plain register port: address, write strobe, write data and combinational read data. Writes take effect at the rising clock edge. The bank is used by steering first and then accessing the shared address.

Top module: `replicated_reg_bank`

## Requirements
- R1: After reset, the steering register at address SEL_ADDR (0x40) reads 0x0001_0000: broadcast flag (bit 16) set, group (bits 15:8) zero and instance (bits 7:0) zero.
- R2: A write to SEL_ADDR loads bits 16:0 into the steering register. Reading SEL_ADDR returns those 17 bits, with the upper bits zero.
- R3: A write to REP_ADDR (0x80) with the broadcast flag set loads the data into every available unit.
- R4: A broadcast write leaves every unavailable unit unchanged.
- R5: A write to REP_ADDR with the flag clear updates only the unit at index group*INST_PER_GROUP+instance, and only if that unit is available.
- R6: A single-target write steered to an unavailable unit changes no unit.
- R7: A read of REP_ADDR returns the steered unit's value, whether the broadcast flag is set or clear.
- R8: A read of REP_ADDR steered to an unavailable unit returns zero.
- R9: A group value of NUM_GROUPS or more, or an instance value of INST_PER_GROUP or more, is treated as unavailable. Reads return zero and single-target writes are dropped.
- R10: Reads of any other address return zero, and writes to any other address change no state.
- R11: Reset clears every unit to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Synchronous reset, active low |
| addr_i | input | ADDR_W | Register address |
| wr_en_i | input | 1 | Write strobe |
| wr_data_i | input | DATA_W | Write data |
| rd_data_o | output | DATA_W | Combinational read data for addr_i |
| avail_i | input | NUM_GROUPS*INST_PER_GROUP | Per-unit presence mask, bit g*INST_PER_GROUP+i |

## Verification
The bench uses several steering patterns. Broadcast writes with part of the mask cleared tell a correct fan-out apart from one that ignores presence. Single-target writes to distinct units, each followed by reads of neighbouring units, show whether the index arithmetic reaches exactly one copy. Reads with the broadcast flag both set and clear, together with out-of-range group and instance values, show whether reads are truly single-unit and whether range checking happens before the availability lookup.

// File: rtl/rrb_pkg.sv
// Shared types for the replicated register bank.
// Assumes a data width of at least 17 bits, so the steering register fits.
package rrb_pkg;
    localparam int FLD_W = 8;

    // Steering register layout: flag at bit 16, group at 15:8, instance at 7:0.
    typedef struct packed {
        logic             mc;
        logic [FLD_W-1:0] grp;
        logic [FLD_W-1:0] inst;
    } steer_t;

    localparam steer_t STEER_RST = '{mc: 1'b1, grp: '0, inst: '0};
endpackage

// File: rtl/steer_decode.sv
// Turns a steering group/instance pair into a flat unit index and a one-hot target.
// Assumes units are numbered g*INST_PER_GROUP+i. A pair outside the range gives in_range=0
// and an all-zero one-hot.
module steer_decode #(
    parameter int NUM_GROUPS     = 2,
    parameter int INST_PER_GROUP = 4,
    localparam int N_UNITS = NUM_GROUPS * INST_PER_GROUP,
    localparam int IDX_W   = (N_UNITS > 1) ? $clog2(N_UNITS) : 1
) (
    input  logic [rrb_pkg::FLD_W-1:0] grp_i,
    input  logic [rrb_pkg::FLD_W-1:0] inst_i,
    output logic                      in_range_o,
    output logic [IDX_W-1:0]          idx_o,
    output logic [N_UNITS-1:0]        onehot_o
);
    int unsigned flat;

    // Range check and index arithmetic.
    always_comb begin
        in_range_o = (32'(grp_i) < NUM_GROUPS) && (32'(inst_i) < INST_PER_GROUP);
        flat       = 32'(grp_i) * INST_PER_GROUP + 32'(inst_i);
        idx_o      = in_range_o ? IDX_W'(flat) : '0;
        onehot_o   = in_range_o ? (N_UNITS'(1) << idx_o) : '0;
    end
endmodule

// File: rtl/rep_unit_array.sv
// Holds one data register per unit.
// A unit loads on a write when it is present and is either the one-hot target
// or addressed by broadcast. Assumes the one-hot input has at most one bit set.
module rep_unit_array #(
    parameter int N_UNITS = 8,
    parameter int DATA_W  = 32
) (
    input  logic                      clk_i,
    input  logic                      rst_ni,
    input  logic                      we_i,
    input  logic                      mc_i,
    input  logic [N_UNITS-1:0]        target_i,
    input  logic [N_UNITS-1:0]        avail_i,
    input  logic [DATA_W-1:0]         wdata_i,
    output logic [N_UNITS*DATA_W-1:0] units_o
);
    for (genvar u = 0; u < N_UNITS; u++) begin : g_unit
        logic [DATA_W-1:0] val_q;

        // Per-unit storage with presence-gated load.
        always_ff @(posedge clk_i) begin
            if (!rst_ni)
                val_q <= '0;
            else if (we_i && avail_i[u] && (mc_i || target_i[u]))
                val_q <= wdata_i;
        end

        assign units_o[u*DATA_W +: DATA_W] = val_q;
    end
endmodule

// File: rtl/replicated_reg_bank.sv
// Top level: a steering register plus a replicated register behind one address.
// Reads are combinational and always pick one unit. Terminated reads return zero.
// Assumes DATA_W >= 17.
module replicated_reg_bank #(
    parameter int              NUM_GROUPS     = 2,
    parameter int              INST_PER_GROUP = 4,
    parameter int              DATA_W         = 32,
    parameter int              ADDR_W         = 8,
    parameter logic [ADDR_W-1:0] SEL_ADDR     = 8'h40,
    parameter logic [ADDR_W-1:0] REP_ADDR     = 8'h80,
    localparam int N_UNITS = NUM_GROUPS * INST_PER_GROUP,
    localparam int IDX_W   = (N_UNITS > 1) ? $clog2(N_UNITS) : 1
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic [ADDR_W-1:0]  addr_i,
    input  logic               wr_en_i,
    input  logic [DATA_W-1:0]  wr_data_i,
    output logic [DATA_W-1:0]  rd_data_o,
    input  logic [N_UNITS-1:0] avail_i
);
    import rrb_pkg::*;

    steer_t                    sel_q;
    logic                      in_range;
    logic [IDX_W-1:0]          idx;
    logic [N_UNITS-1:0]        target;
    logic                      hit_avail;
    logic                      rep_we;
    logic [N_UNITS*DATA_W-1:0] units;

    // Steering register, written at its own address.
    always_ff @(posedge clk_i) begin
        if (!rst_ni)
            sel_q <= STEER_RST;
        else if (wr_en_i && addr_i == SEL_ADDR)
            sel_q <= wr_data_i[$bits(steer_t)-1:0];
    end

    steer_decode #(
        .NUM_GROUPS    (NUM_GROUPS),
        .INST_PER_GROUP(INST_PER_GROUP)
    ) dec_i (
        .grp_i     (sel_q.grp),
        .inst_i    (sel_q.inst),
        .in_range_o(in_range),
        .idx_o     (idx),
        .onehot_o  (target)
    );

    // Steered unit present and in range.
    assign hit_avail = in_range && avail_i[idx];
    assign rep_we    = wr_en_i && addr_i == REP_ADDR;

    rep_unit_array #(
        .N_UNITS(N_UNITS),
        .DATA_W (DATA_W)
    ) arr_i (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .we_i    (rep_we),
        .mc_i    (sel_q.mc),
        .target_i(target),
        .avail_i (avail_i),
        .wdata_i (wr_data_i),
        .units_o (units)
    );

    // Read mux: steering register, steered unit or zero.
    always_comb begin
        rd_data_o = '0;
        if (addr_i == SEL_ADDR)
            rd_data_o = DATA_W'(sel_q);
        else if (addr_i == REP_ADDR && hit_avail)
            rd_data_o = units[idx*DATA_W +: DATA_W];
    end
endmodule

// File: rtl/replicated_reg_bank_chk.sv
// Property checker for the replicated register bank, attached through bind.
// It keeps a one-cycle copy of the unit contents to see which units changed.
module replicated_reg_bank_chk #(
    parameter int              N_UNITS  = 8,
    parameter int              DATA_W   = 32,
    parameter int              ADDR_W   = 8,
    parameter logic [ADDR_W-1:0] SEL_ADDR = 8'h40,
    parameter logic [ADDR_W-1:0] REP_ADDR = 8'h80
) (
    input logic                      clk,
    input logic                      rst_ni,
    input logic [ADDR_W-1:0]         addr,
    input logic                      wr_en,
    input logic [DATA_W-1:0]         wr_data,
    input logic [DATA_W-1:0]         rd_data,
    input logic [N_UNITS-1:0]        avail,
    input logic                      sel_mc,
    input logic                      hit_avail,
    input logic [N_UNITS*DATA_W-1:0] units
);
    logic [N_UNITS*DATA_W-1:0] prev_q;
    logic [N_UNITS-1:0]        chg;

    // Previous-cycle snapshot of unit contents.
    always_ff @(posedge clk) prev_q <= units;

    // Which units differ from the snapshot.
    always_comb
        for (int u = 0; u < N_UNITS; u++)
            chg[u] = units[u*DATA_W +: DATA_W] != prev_q[u*DATA_W +: DATA_W];

    // R2
    sel_write_chk: assert property (@(posedge clk) disable iff (!rst_ni)
        (wr_en && addr == SEL_ADDR) |=> (addr != SEL_ADDR || rd_data == DATA_W'($past(wr_data[16:0]))));

    // R4
    mc_skip_absent_chk: assert property (@(posedge clk) disable iff (!rst_ni)
        (wr_en && addr == REP_ADDR && sel_mc) |=> ((chg & ~$past(avail)) == '0));

    // R5
    uni_single_chk: assert property (@(posedge clk) disable iff (!rst_ni)
        (wr_en && addr == REP_ADDR && !sel_mc) |=> ($countones(chg) <= 1));

    // R6
    uni_drop_chk: assert property (@(posedge clk) disable iff (!rst_ni)
        (wr_en && addr == REP_ADDR && !sel_mc && !hit_avail) |=> (chg == '0));

    // R8
    term_read_chk: assert property (@(posedge clk) disable iff (!rst_ni)
        (addr == REP_ADDR && !hit_avail) |-> (rd_data == '0));

    // R10
    other_addr_chk: assert property (@(posedge clk) disable iff (!rst_ni)
        (!(wr_en && addr == REP_ADDR)) |=> (chg == '0));
endmodule

bind replicated_reg_bank replicated_reg_bank_chk #(
    .N_UNITS (N_UNITS),
    .DATA_W  (DATA_W),
    .ADDR_W  (ADDR_W),
    .SEL_ADDR(SEL_ADDR),
    .REP_ADDR(REP_ADDR)
) chk_i (
    .clk      (clk_i),
    .rst_ni   (rst_ni),
    .addr     (addr_i),
    .wr_en    (wr_en_i),
    .wr_data  (wr_data_i),
    .rd_data  (rd_data_o),
    .avail    (avail_i),
    .sel_mc   (sel_q.mc),
    .hit_avail(hit_avail),
    .units    (units)
);

// File: tb/replicated_reg_bank_tb_top.sv
// Testbench: walks a vector table, then runs directed reset checks.
module replicated_reg_bank_tb_top;
    localparam int NV = 31;

    typedef struct packed {
        logic        wr;
        logic [7:0]  addr;
        logic [31:0] data;
        logic [7:0]  avail;
        logic [31:0] exp;
        logic [7:0]  req;
    } vec_t;

    // Steering word: flag<<16 | group<<8 | instance. SEL=40, REP=80.
    localparam vec_t VEC [NV] = '{
        '{1'b0, 8'h40, 32'h0, 8'hFF, 32'h0001_0000, 8'd1},   // R1 reset steering
        '{1'b0, 8'h80, 32'h0, 8'hFF, 32'h0,         8'd11},  // R11 unit cleared
        '{1'b1, 8'h80, 32'hA5A5_0001, 8'hF3, 32'h0, 8'd3},   // R3 broadcast, units 2,3 absent
        '{1'b1, 8'h40, 32'hFFFE_0000, 8'hF3, 32'h0, 8'd2},   // R2 upper bits ignored
        '{1'b0, 8'h40, 32'h0, 8'hF3, 32'h0,         8'd2},   // R2
        '{1'b0, 8'h80, 32'h0, 8'hF3, 32'hA5A5_0001, 8'd3},   // R3 unit 0
        '{1'b1, 8'h40, 32'h0000_0105, 8'hF3, 32'h0, 8'd2},   // g1 i5 -> out of range
        '{1'b1, 8'h40, 32'h0000_0103, 8'hF3, 32'h0, 8'd2},   // g1 i3 -> unit 7
        '{1'b0, 8'h40, 32'h0, 8'hF3, 32'h0000_0103, 8'd2},   // R2
        '{1'b0, 8'h80, 32'h0, 8'hF3, 32'hA5A5_0001, 8'd3},   // R3 unit 7
        '{1'b1, 8'h40, 32'h0000_0002, 8'hF3, 32'h0, 8'd2},   // g0 i2
        '{1'b0, 8'h80, 32'h0, 8'hF3, 32'h0,         8'd8},   // R8 absent unit reads zero
        '{1'b0, 8'h80, 32'h0, 8'hFF, 32'h0,         8'd4},   // R4 unit 2 untouched
        '{1'b1, 8'h80, 32'h0000_1111, 8'hFF, 32'h0, 8'd5},   // R5 single write unit 2
        '{1'b0, 8'h80, 32'h0, 8'hFF, 32'h0000_1111, 8'd5},   // R5
        '{1'b1, 8'h40, 32'h0000_0003, 8'hFF, 32'h0, 8'd2},   // g0 i3
        '{1'b0, 8'h80, 32'h0, 8'hFF, 32'h0,         8'd5},   // R5 neighbour unit 3 unchanged
        '{1'b1, 8'h40, 32'h0000_0001, 8'hFF, 32'h0, 8'd2},   // g0 i1
        '{1'b0, 8'h80, 32'h0, 8'hFF, 32'hA5A5_0001, 8'd5},   // R5 unit 1 unchanged
        '{1'b1, 8'h40, 32'h0000_0103, 8'hFF, 32'h0, 8'd2},   // g1 i3
        '{1'b1, 8'h80, 32'h0000_2222, 8'h7F, 32'h0, 8'd6},   // R6 write to absent unit 7
        '{1'b0, 8'h80, 32'h0, 8'hFF, 32'hA5A5_0001, 8'd6},   // R6 dropped
        '{1'b1, 8'h40, 32'h0001_0002, 8'hFF, 32'h0, 8'd7},   // flag set, g0 i2
        '{1'b0, 8'h80, 32'h0, 8'hFF, 32'h0000_1111, 8'd7},   // R7 single-unit read
        '{1'b1, 8'h40, 32'h0000_0200, 8'hFF, 32'h0, 8'd9},   // g2: out of range
        '{1'b0, 8'h80, 32'h0, 8'hFF, 32'h0,         8'd9},   // R9 read zero
        '{1'b1, 8'h80, 32'h0000_3333, 8'hFF, 32'h0, 8'd9},   // R9 write dropped
        '{1'b1, 8'h40, 32'h0000_0004, 8'hFF, 32'h0, 8'd9},   // g0 i4: out of range
        '{1'b0, 8'h80, 32'h0, 8'hFF, 32'h0,         8'd9},   // R9
        '{1'b1, 8'h10, 32'hFFFF_FFFF, 8'hFF, 32'h0, 8'd10},  // R10 stray write
        '{1'b0, 8'h10, 32'h0, 8'hFF, 32'h0,         8'd10}   // R10 stray read
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  addr = '0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic [7:0]  avail = 8'hFF;
    int          checks = 0;
    int          errors = 0;
    logic        done = 1'b0;

    always #10 clk = ~clk;

    replicated_reg_bank dut_i (
        .clk_i    (clk),
        .rst_ni   (rst_n),
        .addr_i   (addr),
        .wr_en_i  (wr_en),
        .wr_data_i(wr_data),
        .rd_data_o(rd_data),
        .avail_i  (avail)
    );

    task automatic do_write(input logic [7:0] a, input logic [31:0] d, input logic [7:0] m);
        @(negedge clk);
        addr = a; wr_data = d; avail = m; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic do_read(input logic [7:0] a, input logic [7:0] m,
                           input logic [31:0] exp, input int req);
        @(negedge clk);
        addr = a; avail = m;
        #1;
        checks++;
        if (rd_data !== exp) begin
            errors++;
            $display("FAIL R%0d addr %h actual %h expected %h", req, a, rd_data, exp);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        for (int k = 0; k < NV; k++) begin
            if (VEC[k].wr) do_write(VEC[k].addr, VEC[k].data, VEC[k].avail);
            else           do_read(VEC[k].addr, VEC[k].avail, VEC[k].exp, int'(VEC[k].req));
        end
        // Stray write left unit 0 intact (R10).
        do_write(8'h40, 32'h0000_0000, 8'hFF);
        do_read(8'h80, 8'hFF, 32'hA5A5_0001, 10);
        // Reset mid-run restores steering and clears units (R1, R11).
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        do_read(8'h40, 8'hFF, 32'h0001_0000, 1);
        do_read(8'h80, 8'hFF, 32'h0, 11);
        do_write(8'h40, 32'h0000_0103, 8'hFF);
        do_read(8'h80, 8'hFF, 32'h0, 11);
        done = 1'b1;
    end

    initial begin
        for (int c = 0; c < 5000 && !done; c++) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog expired actual running expected finished");
        end
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule